// File: doc/BRIEF.md
# Shared-Pin Serial EEPROM Access Port

This block lets software drive an external serial EEPROM one bit at a time through a single 8-bit control register. The clock and data-out pins are shared with a memory port. Software therefore first asks for them by setting a request bit. When the memory port reports that it is not busy, the block takes the pins and raises a ready flag. From then on, three register bits drive the EEPROM chip select, clock and data-out lines directly, and a read-only bit returns the level of the EEPROM data output.

After the pins have been granted, every write to the register restarts a ready timer. The timer drops ready at once and raises it again after a fixed delay, nominally 800 ns. That delay is converted into a cycle count from the clock period parameter and rounded up. Software polls ready to pace the serial protocol. The command protocol itself is left to software. Clearing the request bit hands the pins back to the memory port.

Top module: `ee_share_port`

## Requirements
- R1: After reset, the register reads 0x00, `owned_o` is 0, `ee_cs_o` is 0, and the shared pins follow the memory port inputs.
- R2: Register layout is bit 5 request (read/write), bit 4 ready (read-only), bit 3 chip select, bit 2 clock, bit 1 data out (read/write), bit 0 data in (read-only); bits 7:6 read as 0. Writes to bits 7:6, 4 and 0 have no effect.
- R3: The grant (`owned_o`) rises on the first clock edge at which the stored request is 1 and `mem_busy_i` is 0. While `mem_busy_i` stays 1, no grant is given.
- R4: Ready rises in the same cycle as the grant, with no timed delay.
- R5: While granted, a write with bit 5 set clears ready right after its clock edge. Ready reads 1 again exactly DELAY_CYC edges later, where DELAY_CYC = ceil(DELAY_NS*1000 / CLK_PERIOD_PS).
- R6: A write during a running delay restarts the full delay from that write.
- R7: While granted, `ee_cs_o`, `shared_clk_o` and `shared_dout_o` equal register bits 3, 2 and 1, and register bit 0 reads `pin_din_i`.
- R8: While not granted, `ee_cs_o` is 0, `shared_clk_o`/`shared_dout_o` follow `mem_clk_i`/`mem_dout_i`, and register bits 4 and 0 read 0.
- R9: A write with bit 5 clear releases the pins: `owned_o` and ready are 0 right after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| mem_busy_i | input | 1 | Memory port is serving another request |
| mem_clk_i | input | 1 | Memory port drive for the shared clock pin |
| mem_dout_i | input | 1 | Memory port drive for the shared data pin |
| pin_din_i | input | 1 | EEPROM data output line |
| owned_o | output | 1 | Pins are granted to the EEPROM path |
| ee_cs_o | output | 1 | EEPROM chip select |
| shared_clk_o | output | 1 | Shared clock pin |
| shared_dout_o | output | 1 | Shared data-out pin |

## Verification
The bench builds the block with a 4000 ps clock period and a 40 ns delay, which gives a 10-cycle ready timer. With that setting, every timer expiry can be checked at both its last low cycle and its first high cycle, and a retrigger in the middle of a count is still cheap to reach. The short delay lets the bench sweep all eight chip-select/clock/data-out combinations with both data-in levels, each followed by a full timer cycle. It also sweeps every combination of the memory-port pins while the pins are not granted.

// File: rtl/ee_share_pkg.sv
`timescale 1ns/1ps
package ee_share_pkg;
  localparam int unsigned BIT_REQ   = 5;
  localparam int unsigned BIT_READY = 4;
  localparam int unsigned BIT_CS    = 3;
  localparam int unsigned BIT_CLK   = 2;
  localparam int unsigned BIT_DOUT  = 1;
  localparam int unsigned BIT_DIN   = 0;

  typedef struct packed {
    logic cs;
    logic clk;
    logic dout;
  } ee_drive_t;
endpackage

// File: rtl/ee_share_arb.sv
`timescale 1ns/1ps
module ee_share_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_req_i,
  input  logic busy_i,
  output logic req_o,
  output logic grant_o
);
  logic req_q, grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      if (wr_i) req_q <= wr_req_i;
      // release on the clearing write itself; acquire only when port idle
      if (wr_i && !wr_req_i)                 grant_q <= 1'b0;
      else if (!req_q)                       grant_q <= 1'b0;
      else if (!grant_q && !busy_i)          grant_q <= 1'b1;
    end
  end

  assign req_o   = req_q;
  assign grant_o = grant_q;
endmodule

// File: rtl/ee_ready_timer.sv
`timescale 1ns/1ps
module ee_ready_timer #(
  parameter int unsigned DELAY_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic restart_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (restart_i)          cnt_q <= CNT_W'(DELAY_CYC);
    else if (cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/ee_pin_mux.sv
`timescale 1ns/1ps
module ee_pin_mux
  import ee_share_pkg::*;
(
  input  logic      own_i,
  input  ee_drive_t sw_i,
  input  logic      mem_clk_i,
  input  logic      mem_dout_i,
  input  logic      pin_din_i,
  output logic      ee_cs_o,
  output logic      clk_o,
  output logic      dout_o,
  output logic      din_o
);
  always_comb begin
    ee_cs_o = own_i & sw_i.cs;
    clk_o   = own_i ? sw_i.clk  : mem_clk_i;
    dout_o  = own_i ? sw_i.dout : mem_dout_i;
    din_o   = own_i & pin_din_i;
  end
endmodule

// File: rtl/ee_share_port.sv
`timescale 1ns/1ps
module ee_share_port
  import ee_share_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned DELAY_NS      = 800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       mem_busy_i,
  input  logic       mem_clk_i,
  input  logic       mem_dout_i,
  input  logic       pin_din_i,
  output logic       owned_o,
  output logic       ee_cs_o,
  output logic       shared_clk_o,
  output logic       shared_dout_o
);
  localparam int unsigned RAW_CYC   = (DELAY_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned DELAY_CYC = (RAW_CYC == 0) ? 1 : RAW_CYC;

  logic      req, grant, tmr_idle, din_seen, ready;
  ee_drive_t drv_q;
  logic      unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[7:6], reg_wdata_i[BIT_READY], reg_wdata_i[BIT_DIN]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else if (reg_wr_i) begin
      drv_q.cs   <= reg_wdata_i[BIT_CS];
      drv_q.clk  <= reg_wdata_i[BIT_CLK];
      drv_q.dout <= reg_wdata_i[BIT_DOUT];
    end
  end

  ee_share_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wr_req_i (reg_wdata_i[BIT_REQ]),
    .busy_i   (mem_busy_i),
    .req_o    (req),
    .grant_o  (grant)
  );

  ee_ready_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!grant),
    .restart_i (reg_wr_i && grant && reg_wdata_i[BIT_REQ]),
    .idle_o    (tmr_idle)
  );

  ee_pin_mux u_mux (
    .own_i      (grant),
    .sw_i       (drv_q),
    .mem_clk_i  (mem_clk_i),
    .mem_dout_i (mem_dout_i),
    .pin_din_i  (pin_din_i),
    .ee_cs_o    (ee_cs_o),
    .clk_o      (shared_clk_o),
    .dout_o     (shared_dout_o),
    .din_o      (din_seen)
  );

  assign ready       = grant & tmr_idle;
  assign owned_o     = grant;
  assign reg_rdata_o = {2'b00, req, ready, drv_q.cs, drv_q.clk, drv_q.dout, din_seen};
endmodule

// File: rtl/ee_share_port_chk.sv
`timescale 1ns/1ps
module ee_share_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_wr_i,
  input logic wr_req_bit_i,
  input logic ready_i,
  input logic sw_clk_bit_i,
  input logic mem_busy_i,
  input logic mem_clk_i,
  input logic owned_o,
  input logic ee_cs_o,
  input logic shared_clk_o
);
  assert_grant_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owned_o) |-> $past(!mem_busy_i));

  assert_ready_with_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owned_o) |-> ready_i);

  assert_ready_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && owned_o && wr_req_bit_i) |=> !ready_i);

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !wr_req_bit_i) |=> (!owned_o && !ready_i));

  assert_idle_pins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owned_o |-> (!ee_cs_o && !ready_i && shared_clk_o == mem_clk_i));

  assert_owned_clk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned_o |-> (shared_clk_o == sw_clk_bit_i));
endmodule

bind ee_share_port ee_share_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .wr_req_bit_i (reg_wdata_i[5]),
  .ready_i      (reg_rdata_o[4]),
  .sw_clk_bit_i (reg_rdata_o[2]),
  .mem_busy_i   (mem_busy_i),
  .mem_clk_i    (mem_clk_i),
  .owned_o      (owned_o),
  .ee_cs_o      (ee_cs_o),
  .shared_clk_o (shared_clk_o)
);

// File: tb/ee_share_port_test.sv
`timescale 1ns/1ps
module ee_share_port_test;
  localparam int unsigned PER_PS = 4000;
  localparam int unsigned DLY_NS = 40;
  localparam int unsigned D      = (DLY_NS * 1000 + PER_PS - 1) / PER_PS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       mem_busy = 1'b0, mem_clk = 1'b0, mem_dout = 1'b0, pin_din = 1'b0;
  logic       owned, ee_cs, sh_clk, sh_dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ee_share_port #(.CLK_PERIOD_PS(PER_PS), .DELAY_NS(DLY_NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mem_busy_i(mem_busy), .mem_clk_i(mem_clk),
    .mem_dout_i(mem_dout), .pin_din_i(pin_din), .owned_o(owned), .ee_cs_o(ee_cs),
    .shared_clk_o(sh_clk), .shared_dout_o(sh_dout)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mem_clk = 1'b1;
    #9 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 owned", {7'd0, owned}, 8'h00);
    chk("R1 cs", {7'd0, ee_cs}, 8'h00);
    chk("R1 shared clk", {7'd0, sh_clk}, 8'h01);

    // R8 sweep memory-port pins and din while not granted
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        mem_clk = m[1]; mem_dout = m[0]; pin_din = d[0];
        #1;
        chk("R8 pins", {4'd0, ee_cs, sh_clk, sh_dout, reg_rdata[0]}, {4'd0, 1'b0, m[1], m[0], 1'b0});
      end
    end

    // R2 readback and read-only bits; R3 hold off while busy
    mem_busy = 1'b1; pin_din = 1'b1;
    wr(8'hFF);
    chk("R2 readback", reg_rdata, 8'h2E);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 busy holds", {7'd0, owned}, 8'h00);
    end
    mem_busy = 1'b0;
    tick();
    chk("R3 grant", {7'd0, owned}, 8'h01);
    chk("R4 ready with grant", {7'd0, reg_rdata[4]}, 8'h01);
    chk("R7 din visible", {7'd0, reg_rdata[0]}, 8'h01);

    // R7/R5 sweep drive bits and din while granted
    for (int v = 0; v < 8; v++) begin
      for (int d = 0; d < 2; d++) begin
        logic [2:0] vv;
        vv = v[2:0];
        pin_din = d[0];
        mem_clk = ~vv[1]; mem_dout = ~vv[0];
        wr({2'b00, 1'b1, 1'b0, vv, 1'b0});
        chk("R7 pins", {5'd0, ee_cs, sh_clk, sh_dout}, {5'd0, vv});
        chk("R7 din", {7'd0, reg_rdata[0]}, {7'd0, d[0]});
        chk("R5 ready cleared", {7'd0, reg_rdata[4]}, 8'h00);
        for (int k = 0; k < int'(D) - 1; k++) tick();
        chk("R5 ready still low", {7'd0, reg_rdata[4]}, 8'h00);
        tick();
        chk("R5 ready back", {7'd0, reg_rdata[4]}, 8'h01);
      end
    end

    // R6 retrigger mid-count
    wr(8'h28);
    for (int k = 0; k < 4; k++) tick();
    wr(8'h28);
    for (int k = 0; k < int'(D) - 1; k++) tick();
    chk("R6 restart low", {7'd0, reg_rdata[4]}, 8'h00);
    tick();
    chk("R6 restart high", {7'd0, reg_rdata[4]}, 8'h01);

    // R9 release
    mem_clk = 1'b1; mem_dout = 1'b0;
    wr(8'h0E);
    chk("R9 owned", {7'd0, owned}, 8'h00);
    chk("R9 rdata", reg_rdata, 8'h0E);
    chk("R9 pins back", {5'd0, ee_cs, sh_clk, sh_dout}, 8'h02);

    // R3 re-request with idle port
    wr(8'h20);
    chk("R3 not yet", {7'd0, owned}, 8'h00);
    tick();
    chk("R3 regrant", {7'd0, owned}, 8'h01);
    chk("R4 regrant ready", {7'd0, reg_rdata[4]}, 8'h01);

    finish_run();
  end
endmodule